// File: doc/BRIEF.md
# External Interrupt Request Conditioner

This block conditions a small set of active-low external interrupt request pins for a pipelined processor. Each pin has a 3-bit configuration field. The field selects level or falling-edge triggering and a 2-bit priority code, where code 0 turns the pin off. Pin inputs are synchronised. Falling edges are captured in a per-pin latch, and the block presents the most urgent enabled pending request to the processor's arbitration logic as a valid flag, a pin index and a priority level.

The block then follows the sequencer's two-word vector fetch handshake. Fetching the first vector word moves the presented request into an accepted (in-service) state. Fetching the second vector word completes service and clears the edge latch of that pin. A discarded first-word fetch, such as one pre-empted by a software interrupt decoded in the same slot, drops the accepted state and leaves the request pending so that it is taken again later. While a request is accepted, turning its pin off does not cancel it.

Top module: `xirq_ctrl`

## Requirements
- R1: After a synchronous reset, `pend`, `req_valid` and `acc_valid` are 0 and every pin is disabled (priority code 00), so a low pin raises no request.
- R2: A pin whose priority code is 00 raises no pending flag in either trigger mode.
- R3: In edge mode (configuration bit 3i+2 = 1) with the pin enabled, a high-to-low change on `irq_n[i]` sets `pend[i]` after the third rising clock edge. `pend[i]` stays set after the pin returns high.
- R4: In edge mode the edge latch is held clear while the pin is disabled. An edge seen while disabled is therefore lost, and enabling the pin with its input already low raises nothing.
- R5: In level mode (bit 3i+2 = 0) with the pin enabled, `pend[i]` follows the low pin after the second rising clock edge. Disabling the pin before its first vector fetch cancels `pend[i]` on the edge that writes the configuration.
- R6: `req_valid` is set when any enabled pin is pending. `req_pin` is the pending pin with the largest priority code (bits 3i+1:3i), with the lower index winning ties, and `req_level` is that code minus 1.
- R7: A `vec1_fetch` pulse while `req_valid` is set and `acc_valid` is clear sets `acc_valid` on the next edge and latches `acc_pin` to the presented `req_pin`.
- R8: While a pin is accepted, its `pend` bit stays set, including when the pin is disabled or, in level mode, its input goes high.
- R9: A `vec2_fetch` pulse while accepted clears `acc_valid` and clears the accepted pin's edge latch, so that `pend` drops with no new edge.
- R10: A `vec1_discard` pulse while accepted clears `acc_valid` and keeps the edge-mode request pending, so that it is presented again.
- R11: The first-vector fetch alone does not clear the edge latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_n | input | NPIN | Active-low request pins, asynchronous |
| cfg_we | input | 1 | Write strobe for the configuration register |
| cfg_wdata | input | 3*NPIN | Per pin i: bits 3i+1:3i priority code, bit 3i+2 edge mode |
| vec1_fetch | input | 1 | Sequencer fetched the first vector word |
| vec2_fetch | input | 1 | Sequencer fetched the second vector word |
| vec1_discard | input | 1 | First vector fetch was thrown away |
| pend | output | NPIN | Per-pin pending flags |
| req_valid | output | 1 | An enabled request is presented |
| req_pin | output | IDX_W | Index of the presented pin |
| req_level | output | 2 | Priority level of the presented request (0 to 2) |
| acc_valid | output | 1 | A request is in service |
| acc_pin | output | IDX_W | Index of the pin in service |

## Verification
An edge latch in the wrong state shows on `pend` as a request that appears with no edge, fails to appear three edges after one, or survives a completed second-vector fetch. All of these are visible on the cycle after the triggering handshake pulse or configuration write. A wrong accepted state shows on `acc_valid`/`acc_pin` one edge after a fetch pulse, and as a `pend` bit that drops while its pin is in service. Arbitration faults show directly on `req_pin`/`req_level` for chosen mixes of priority codes and pin levels.

// File: rtl/xirq_pkg.sv
package xirq_pkg;
   localparam int PRIO_W = 2;

   typedef enum logic {
      TRIG_LEVEL = 1'b0,
      TRIG_EDGE  = 1'b1
   } trig_e;

   // one configuration field per pin: {trig, prio}
   typedef struct packed {
      trig_e             trig;
      logic [PRIO_W-1:0] prio;
   } pin_cfg_t;

   localparam int CFG_W = $bits(pin_cfg_t);
endpackage

// File: rtl/xirq_sync.sv
module xirq_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic d,
   output logic q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("xirq_sync needs at least two stages");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk) begin
      if (rst) chain <= {STAGES{RST_VAL}};
      else     chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/xirq_pin.sv
module xirq_pin
   import xirq_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic     clk,
   input  logic     rst,
   input  logic     pin_n,
   input  pin_cfg_t cfg,
   input  logic     in_service,
   input  logic     done,
   output logic     pend
);
   logic pin_s;
   logic pin_prev;
   logic latch_q;
   logic enabled;
   logic fall;
   logic keep;

   xirq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) sync_i (
      .clk (clk),
      .rst (rst),
      .d   (pin_n),
      .q   (pin_s)
   );

   assign enabled = (cfg.prio != '0);
   assign fall    = pin_prev & ~pin_s;
   // the latch survives a disable only while its request is in service
   assign keep    = (cfg.trig == TRIG_EDGE) && (enabled || in_service);

   always_ff @(posedge clk) begin
      if (rst) begin
         pin_prev <= 1'b1;
         latch_q  <= 1'b0;
      end else begin
         pin_prev <= pin_s;
         if (!keep) latch_q <= 1'b0;
         else       latch_q <= (latch_q & ~done) | (fall & enabled);
      end
   end

   always_comb begin
      if (cfg.trig == TRIG_EDGE) pend = in_service | (enabled & latch_q);
      else                       pend = in_service | (enabled & ~pin_s);
   end
endmodule

// File: rtl/xirq_arb.sv
module xirq_arb
   import xirq_pkg::*;
#(
   parameter int NPIN  = 2,
   parameter int IDX_W = 1
) (
   input  logic [NPIN-1:0]   cand,
   input  logic [PRIO_W-1:0] prio [NPIN],
   output logic              valid,
   output logic [IDX_W-1:0]  idx,
   output logic [PRIO_W-1:0] level
);
   logic [PRIO_W-1:0] best;

   always_comb begin
      valid = 1'b0;
      idx   = '0;
      best  = '0;
      // walk downwards with >= so the lowest index wins equal codes
      for (int i = NPIN - 1; i >= 0; i--) begin
         if (cand[i] && prio[i] != '0 && prio[i] >= best) begin
            valid = 1'b1;
            idx   = IDX_W'(i);
            best  = prio[i];
         end
      end
      level = valid ? best - 1'b1 : '0;
   end
endmodule

// File: rtl/xirq_ctrl.sv
module xirq_ctrl
   import xirq_pkg::*;
#(
   parameter int NPIN        = 2,
   parameter int SYNC_STAGES = 2,
   localparam int IDX_W      = (NPIN > 1) ? $clog2(NPIN) : 1
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic [NPIN-1:0]      irq_n,
   input  logic                 cfg_we,
   input  logic [NPIN*CFG_W-1:0] cfg_wdata,
   input  logic                 vec1_fetch,
   input  logic                 vec2_fetch,
   input  logic                 vec1_discard,
   output logic [NPIN-1:0]      pend,
   output logic                 req_valid,
   output logic [IDX_W-1:0]     req_pin,
   output logic [PRIO_W-1:0]    req_level,
   output logic                 acc_valid,
   output logic [IDX_W-1:0]     acc_pin
);
   generate
      if (NPIN < 1 || NPIN > 16) begin : g_bad_npin
         $error("xirq_ctrl: NPIN out of range");
      end
   endgenerate

   pin_cfg_t          cfg_q [NPIN];
   logic [PRIO_W-1:0] prio_v [NPIN];
   logic [NPIN-1:0]   in_svc;
   logic [NPIN-1:0]   done_v;

   always_ff @(posedge clk) begin
      for (int i = 0; i < NPIN; i++) begin
         if (rst)         cfg_q[i] <= '{trig: TRIG_LEVEL, prio: '0};
         else if (cfg_we) cfg_q[i] <= pin_cfg_t'(cfg_wdata[CFG_W*i +: CFG_W]);
      end
   end

   generate
      for (genvar g = 0; g < NPIN; g++) begin : g_pin
         assign prio_v[g] = cfg_q[g].prio;
         assign in_svc[g] = acc_valid && (acc_pin == IDX_W'(g));
         assign done_v[g] = in_svc[g] && vec2_fetch;

         xirq_pin #(.SYNC_STAGES(SYNC_STAGES)) pin_i (
            .clk        (clk),
            .rst        (rst),
            .pin_n      (irq_n[g]),
            .cfg        (cfg_q[g]),
            .in_service (in_svc[g]),
            .done       (done_v[g]),
            .pend       (pend[g])
         );
      end
   endgenerate

   xirq_arb #(.NPIN(NPIN), .IDX_W(IDX_W)) arb_i (
      .cand  (pend),
      .prio  (prio_v),
      .valid (req_valid),
      .idx   (req_pin),
      .level (req_level)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         acc_valid <= 1'b0;
         acc_pin   <= '0;
      end else if (acc_valid) begin
         if (vec2_fetch || vec1_discard) acc_valid <= 1'b0;
      end else if (vec1_fetch && req_valid) begin
         acc_valid <= 1'b1;
         acc_pin   <= req_pin;
      end
   end
endmodule

// File: rtl/xirq_ctrl_chk.sv
module xirq_ctrl_chk #(
   parameter int NPIN  = 2,
   parameter int IDX_W = 1
) (
   input logic             clk,
   input logic             rst,
   input logic [NPIN-1:0]  pend,
   input logic             req_valid,
   input logic [IDX_W-1:0] req_pin,
   input logic             acc_valid,
   input logic [IDX_W-1:0] acc_pin,
   input logic             vec1_fetch,
   input logic             vec2_fetch,
   input logic             vec1_discard
);
   a_r7_accept: assert property (@(posedge clk) disable iff (rst)
      (!acc_valid && req_valid && vec1_fetch) |=> (acc_valid && acc_pin == $past(req_pin)));

   a_r8_svc_pending: assert property (@(posedge clk) disable iff (rst)
      acc_valid |-> pend[acc_pin]);

   a_r8_svc_stays: assert property (@(posedge clk) disable iff (rst)
      (acc_valid && !vec2_fetch && !vec1_discard) |=> (acc_valid && $stable(acc_pin)));

   a_r9_complete: assert property (@(posedge clk) disable iff (rst)
      (acc_valid && vec2_fetch) |=> !acc_valid);

   a_r10_discard: assert property (@(posedge clk) disable iff (rst)
      (acc_valid && vec1_discard) |=> !acc_valid);

   a_r6_presented_pending: assert property (@(posedge clk) disable iff (rst)
      req_valid |-> pend[req_pin]);
endmodule

bind xirq_ctrl xirq_ctrl_chk #(.NPIN(NPIN), .IDX_W(IDX_W)) chk_i (
   .clk          (clk),
   .rst          (rst),
   .pend         (pend),
   .req_valid    (req_valid),
   .req_pin      (req_pin),
   .acc_valid    (acc_valid),
   .acc_pin      (acc_pin),
   .vec1_fetch   (vec1_fetch),
   .vec2_fetch   (vec2_fetch),
   .vec1_discard (vec1_discard)
);

// File: tb/xirq_ctrl_tb.sv
module xirq_ctrl_tb_top;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [1:0] irq_n = 2'b11;
   logic       cfg_we = 1'b0;
   logic [5:0] cfg_wdata = '0;
   logic       vec1_fetch = 1'b0;
   logic       vec2_fetch = 1'b0;
   logic       vec1_discard = 1'b0;
   logic [1:0] pend;
   logic       req_valid;
   logic [0:0] req_pin;
   logic [1:0] req_level;
   logic       acc_valid;
   logic [0:0] acc_pin;

   int n_chk = 0;
   int n_bad = 0;

   always #2 clk = ~clk;

   xirq_ctrl dut_i (
      .clk(clk), .rst(rst), .irq_n(irq_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
      .vec1_fetch(vec1_fetch), .vec2_fetch(vec2_fetch), .vec1_discard(vec1_discard),
      .pend(pend), .req_valid(req_valid), .req_pin(req_pin), .req_level(req_level),
      .acc_valid(acc_valid), .acc_pin(acc_pin)
   );

   // {cfg {edgeB,prioB,edgeA,prioA}, pins {B,A}, exp valid, exp pin, exp level}
   localparam logic [11:0] TBL [8] = '{
      12'b000001_00_1_0_00,
      12'b011000_00_1_1_10,
      12'b011010_00_1_1_10,
      12'b011011_00_1_0_10,
      12'b010011_01_1_1_01,
      12'b001001_11_0_0_00,
      12'b000000_00_0_0_00,
      12'b001010_00_1_0_01
   };

   task automatic tick(int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %0h expected %0h", tag, got, exp);
      end
   endtask

   task automatic wr_cfg(logic [5:0] v);
      cfg_wdata = v;
      cfg_we = 1'b1;
      tick(1);
      cfg_we = 1'b0;
   endtask

   task automatic p_vec1;    vec1_fetch = 1'b1;   tick(1); vec1_fetch = 1'b0;   endtask
   task automatic p_vec2;    vec2_fetch = 1'b1;   tick(1); vec2_fetch = 1'b0;   endtask
   task automatic p_discard; vec1_discard = 1'b1; tick(1); vec1_discard = 1'b0; endtask

   initial begin
      #100us;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got hang expected finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      tick(3);
      rst = 1'b0;
      tick(1);
      // R1: reset state, then a low pin with reset configuration
      chk("R1 pend", 8'(pend), 8'h0);
      chk("R1 req_valid", 8'(req_valid), 8'h0);
      chk("R1 acc_valid", 8'(acc_valid), 8'h0);
      irq_n = 2'b00;
      tick(3);
      chk("R1 disabled after reset", {6'b0, pend}, 8'h0);

      // table walk: level mode arbitration (R6) and disabled pins (R2)
      for (int i = 0; i < 8; i++) begin
         irq_n = TBL[i][5:4];
         wr_cfg(TBL[i][11:6]);
         tick(2);
         chk((i == 6) ? "R2 table" : "R6 table",
             {4'b0, req_valid, req_pin, req_level}, {4'b0, TBL[i][3:0]});
      end

      irq_n = 2'b11;
      wr_cfg(6'b000000);
      tick(3);

      // R3: edge mode on pin A, priority code 01
      wr_cfg(6'b000101);
      irq_n[0] = 1'b0;
      tick(2);
      chk("R3 not yet", {6'b0, pend}, 8'h0);
      tick(1);
      chk("R3 edge latched", {6'b0, pend}, 8'h1);
      irq_n[0] = 1'b1;
      tick(3);
      chk("R3 held after release", {6'b0, pend}, 8'h1);

      // R7 / R11: first vector fetch
      p_vec1;
      chk("R7 accepted", {6'b0, acc_valid, acc_pin}, 8'h2);
      chk("R11 latch kept on first fetch", {6'b0, pend}, 8'h1);

      // R8: disable during service, edge mode kept
      wr_cfg(6'b000100);
      tick(2);
      chk("R8 edge survives disable", {6'b0, pend}, 8'h1);

      // R9: second vector fetch
      p_vec2;
      chk("R9 acc cleared", 8'(acc_valid), 8'h0);
      chk("R9 latch cleared", {6'b0, pend}, 8'h0);

      // R10: discarded first fetch keeps the request
      wr_cfg(6'b000101);
      irq_n[0] = 1'b0;
      tick(3);
      chk("R10 pending before", {6'b0, pend}, 8'h1);
      p_vec1;
      chk("R7 accepted again", 8'(acc_valid), 8'h1);
      p_discard;
      chk("R10 acc cleared", 8'(acc_valid), 8'h0);
      chk("R10 still pending", {6'b0, pend}, 8'h1);
      chk("R10 re-presented", {5'b0, req_valid, req_pin}, 8'h2);
      p_vec1;
      p_vec2;
      chk("R9 complete after retry", {5'b0, acc_valid, pend}, 8'h0);
      irq_n[0] = 1'b1;
      tick(3);

      // R4 / R2: edge mode on pin B while disabled
      wr_cfg(6'b100101);
      irq_n[1] = 1'b0;
      tick(3);
      chk("R2 edge pin disabled", {6'b0, pend}, 8'h0);
      wr_cfg(6'b101101);
      tick(3);
      chk("R4 lost edge", {6'b0, pend}, 8'h0);
      irq_n[1] = 1'b1;
      tick(3);
      irq_n[1] = 1'b0;
      tick(3);
      chk("R3 edge on pin B", {6'b0, pend}, 8'h2);
      p_vec1;
      chk("R7 pin B accepted", {6'b0, acc_valid, acc_pin}, 8'h3);
      p_vec2;
      chk("R9 pin B done", {5'b0, acc_valid, pend}, 8'h0);
      irq_n[1] = 1'b1;
      tick(3);

      // R5: level mode on pin A
      wr_cfg(6'b000001);
      irq_n[0] = 1'b0;
      tick(1);
      chk("R5 not yet", {6'b0, pend}, 8'h0);
      tick(1);
      chk("R5 level pending", {6'b0, pend}, 8'h1);
      wr_cfg(6'b000000);
      chk("R5 cancelled by disable", {6'b0, pend}, 8'h0);

      // R8: level request held while in service
      wr_cfg(6'b000001);
      chk("R5 pending again", {6'b0, pend}, 8'h1);
      p_vec1;
      irq_n[0] = 1'b1;
      tick(3);
      chk("R8 level held after release", {6'b0, pend}, 8'h1);
      wr_cfg(6'b000000);
      chk("R8 level held after disable", {6'b0, pend}, 8'h1);
      p_vec2;
      chk("R9 level done", {5'b0, acc_valid, pend}, 8'h0);

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule